// File: doc/BRIEF.md
# Pseudo-Signature Accumulator

This block folds a stream of 16-bit data words into a 16-bit signature. The result lets a controller check a whole memory range with one comparison. When a range has been written, the controller sends each expected word. When a range has been erased, it asserts the erase-check mode and the block uses an all-ones word in place of each data word. Once the last word is in, the controller presents the signature read back from the target together with a compare strobe. The block then records whether the two values are equal.

A start strobe seeds the signature from the start address of the range, less a fixed offset, and clears the word count and the match flag. After that the block absorbs one word on every clock cycle that carries a valid strobe. The running signature and the number of words absorbed are visible on the outputs at all times.

Top module: `psa_sig_accum`

## Requirements
- R1: After reset, the signature, the match flag and the word count are all zero.
- R2: A start strobe loads the signature with the start address minus 2, modulo 2^16, so address 0x0001 yields 0xFFFF and address 0x0000 yields 0xFFFE. The new value is visible on the cycle after the strobe.
- R3: When an absorbed word arrives and signature bit 15 is 1, the new signature is the old signature XORed with 0x0805, shifted left by one, with bit 0 set to 1, and then XORed with the data word.
- R4: When an absorbed word arrives and signature bit 15 is 0, the new signature is the old signature shifted left by one and then XORed with the data word.
- R5: While the erase-check mode input is 1, an absorbed word uses 0xFFFF in place of the data input.
- R6: A word is absorbed on every clock cycle that has the valid strobe high, including back-to-back cycles. Each update is visible on the following cycle.
- R7: When start and valid are high in the same cycle, start takes effect and the word is discarded.
- R8: In a cycle with neither start nor valid high, the signature keeps its value.
- R9: On a compare strobe, the match flag becomes 1 on the next cycle if the read-back input equals the signature held before that edge, and 0 otherwise. A word absorbed in the same cycle does not affect this comparison.
- R10: The match flag changes only on a compare strobe or a start. A start clears it, and a start wins over a compare in the same cycle.
- R11: The word count increments once for each absorbed word, wraps modulo 2^CNT_W, and is cleared by a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Seed strobe |
| start_addr_i | input | 16 | Start address of the range |
| word_vld_i | input | 1 | Data word valid |
| word_i | input | 16 | Data word |
| erase_mode_i | input | 1 | Use an all-ones word in place of word_i |
| cmp_i | input | 1 | Compare strobe |
| readback_i | input | 16 | Signature read back from the target |
| sig_o | output | 16 | Running signature |
| match_o | output | 1 | Result of the last compare |
| count_o | output | CNT_W | Words absorbed since the last start |

## Verification
The bench builds the block with the default polynomial and seed offset and with CNT_W set to 4. The narrow count wraps after 16 words, so the modulo behaviour of R11 is exercised many times within a short random run. The seed offset of 2 lets starts at addresses 0 and 1 test the modulo behaviour of the seed subtraction in R2. In the random phase, roughly half of the compares use the bench's own signature as the read-back value, so both outcomes of the match flag occur, including compares that coincide with a word update.

// File: rtl/psa_sig_pkg.sv
package psa_sig_pkg;
  localparam int SIG_W = 16;
  typedef logic [SIG_W-1:0] sig_t;

  // Seed value: address less the fixed offset, wrapped to the register width.
  function automatic sig_t psa_seed(input sig_t addr, input sig_t dec);
    return addr - dec;
  endfunction

  // Feedback step applied before the data is mixed in.
  function automatic sig_t psa_fold(input sig_t s, input sig_t poly);
    sig_t t;
    if (s[SIG_W-1]) begin
      t = s ^ poly;
      t = {t[SIG_W-2:0], 1'b1};
    end else begin
      t = {s[SIG_W-2:0], 1'b0};
    end
    return t;
  endfunction

  // Word mixed into the register: real data or the erased pattern.
  function automatic sig_t psa_fill(input sig_t d, input logic erase);
    return erase ? {SIG_W{1'b1}} : d;
  endfunction
endpackage

// File: rtl/psa_sig_reg.sv
module psa_sig_reg
  import psa_sig_pkg::*;
#(
  parameter sig_t POLY     = 16'h0805,
  parameter sig_t SEED_DEC = 16'd2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  sig_t seed_addr_i,
  input  logic absorb_i,
  input  sig_t word_i,
  input  logic erase_i,
  output sig_t sig_o
);
  sig_t sig_q;
  sig_t fill_w;
  sig_t next_w;

  assign fill_w = psa_fill(word_i, erase_i);
  assign next_w = psa_fold(sig_q, POLY) ^ fill_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_q <= '0;
    end else if (load_i) begin
      sig_q <= psa_seed(seed_addr_i, SEED_DEC);
    end else if (absorb_i) begin
      sig_q <= next_w;
    end
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/psa_word_count.sv
module psa_word_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/psa_match_reg.sv
module psa_match_reg
  import psa_sig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic cmp_i,
  input  sig_t expect_i,
  input  sig_t readback_i,
  output logic match_o
);
  logic match_q;
  logic equal_w;

  assign equal_w = (expect_i == readback_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= 1'b0;
    end else if (clear_i) begin
      match_q <= 1'b0;
    end else if (cmp_i) begin
      match_q <= equal_w;
    end
  end

  assign match_o = match_q;
endmodule

// File: rtl/psa_sig_accum.sv
module psa_sig_accum
  import psa_sig_pkg::*;
#(
  parameter sig_t POLY     = 16'h0805,
  parameter sig_t SEED_DEC = 16'd2,
  parameter int   CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [15:0]      start_addr_i,
  input  logic             word_vld_i,
  input  logic [15:0]      word_i,
  input  logic             erase_mode_i,
  input  logic             cmp_i,
  input  logic [15:0]      readback_i,
  output logic [15:0]      sig_o,
  output logic             match_o,
  output logic [CNT_W-1:0] count_o
);
  // Named events: start wins over both a word and a compare.
  logic absorb_w;
  logic cmp_w;
  sig_t sig_w;

  assign absorb_w = word_vld_i & ~start_i;
  assign cmp_w    = cmp_i & ~start_i;

  psa_sig_reg #(.POLY(POLY), .SEED_DEC(SEED_DEC)) u_sig (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (start_i),
    .seed_addr_i (start_addr_i),
    .absorb_i    (absorb_w),
    .word_i      (word_i),
    .erase_i     (erase_mode_i),
    .sig_o       (sig_w)
  );

  psa_word_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_i),
    .inc_i   (absorb_w),
    .count_o (count_o)
  );

  psa_match_reg u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_i),
    .cmp_i      (cmp_w),
    .expect_i   (sig_w),
    .readback_i (readback_i),
    .match_o    (match_o)
  );

  assign sig_o = sig_w;
endmodule

// File: rtl/psa_sig_accum_chk.sv
module psa_sig_accum_chk #(
  parameter logic [15:0] POLY     = 16'h0805,
  parameter logic [15:0] SEED_DEC = 16'd2,
  parameter int          CNT_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [15:0]      start_addr_i,
  input logic             word_vld_i,
  input logic [15:0]      word_i,
  input logic             erase_mode_i,
  input logic             cmp_i,
  input logic [15:0]      readback_i,
  input logic [15:0]      sig_o,
  input logic             match_o,
  input logic [CNT_W-1:0] count_o,
  input logic             absorb_w,
  input logic             cmp_w
);
  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> sig_o == 16'($past(start_addr_i) - SEED_DEC));

  // R3 R4 R5 R6
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    absorb_w |=> sig_o == ((({$past(sig_o[14:0]), 1'b0})
                            ^ ($past(sig_o[15]) ? {POLY[14:0], 1'b1} : 16'h0000))
                           ^ ($past(erase_mode_i) ? 16'hFFFF : $past(word_i))));

  // R8
  sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !word_vld_i) |=> $stable(sig_o));

  // R9
  match_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_w |=> match_o == ($past(readback_i) == $past(sig_o)));

  // R10
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !match_o);

  // R10
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !cmp_i) |=> $stable(match_o));

  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    absorb_w |=> count_o == CNT_W'($past(count_o) + 1'b1));

  // R11
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> count_o == '0);
endmodule

bind psa_sig_accum psa_sig_accum_chk #(
  .POLY(POLY), .SEED_DEC(SEED_DEC), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .start_addr_i (start_addr_i),
  .word_vld_i   (word_vld_i),
  .word_i       (word_i),
  .erase_mode_i (erase_mode_i),
  .cmp_i        (cmp_i),
  .readback_i   (readback_i),
  .sig_o        (sig_o),
  .match_o      (match_o),
  .count_o      (count_o),
  .absorb_w     (absorb_w),
  .cmp_w        (cmp_w)
);

// File: tb/psa_sig_accum_tb.sv
module psa_sig_accum_tb;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [15:0]   start_addr_i = '0;
  logic          word_vld_i = 1'b0;
  logic [15:0]   word_i = '0;
  logic          erase_mode_i = 1'b0;
  logic          cmp_i = 1'b0;
  logic [15:0]   readback_i = '0;
  logic [15:0]   sig_o;
  logic          match_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0]   m_sig = '0;
  logic          m_match = 1'b0;
  logic [CW-1:0] m_cnt = '0;

  always #4 clk = ~clk;

  psa_sig_accum #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .word_vld_i(word_vld_i), .word_i(word_i), .erase_mode_i(erase_mode_i),
    .cmp_i(cmp_i), .readback_i(readback_i), .sig_o(sig_o), .match_o(match_o),
    .count_o(count_o)
  );

  // Update rule restated from the requirements.
  function automatic logic [15:0] ref_next(input logic [15:0] s, input logic [15:0] d);
    logic [15:0] t;
    if (s[15] == 1'b1) t = ((s ^ 16'h0805) << 1) | 16'h0001;
    else               t = s << 1;
    return t ^ d;
  endfunction

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check16({tag, " sig"}, sig_o, m_sig);
    check16({tag, " match"}, {15'd0, match_o}, {15'd0, m_match});
    check16({tag, " count"}, {12'd0, count_o}, {12'd0, m_cnt});
  endtask

  // Drive at negedge, update the model on the edge, compare at the next negedge.
  task automatic cycle(input string tag, input logic st, input logic [15:0] addr,
                       input logic vld, input logic [15:0] w, input logic er,
                       input logic cp, input logic [15:0] rb);
    logic [15:0] s0;
    start_i = st; start_addr_i = addr; word_vld_i = vld; word_i = w;
    erase_mode_i = er; cmp_i = cp; readback_i = rb;
    @(posedge clk);
    s0 = m_sig;
    if (st) begin
      m_sig = addr - 16'd2; m_cnt = '0; m_match = 1'b0;
    end else begin
      if (cp) m_match = (rb == s0);
      if (vld) begin
        m_sig = ref_next(s0, er ? 16'hFFFF : w);
        m_cnt = m_cnt + 1'b1;
      end
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    cycle("R2 seed wrap 1", 1, 16'h0001, 0, 0, 0, 0, 0);
    check16("R2 seed 0xFFFF", sig_o, 16'hFFFF);
    cycle("R2 seed wrap 0", 1, 16'h0000, 0, 0, 0, 0, 0);
    check16("R2 seed 0xFFFE", sig_o, 16'hFFFE);
    cycle("R3 msb set", 0, 0, 1, 16'h1234, 0, 0, 0);
    cycle("R2 seed", 1, 16'h0102, 0, 0, 0, 0, 0);
    cycle("R4 msb clear", 0, 0, 1, 16'hA5A5, 0, 0, 0);
    cycle("R5 erase", 0, 0, 1, 16'h0000, 1, 0, 0);
    cycle("R6 back to back", 0, 0, 1, 16'h00FF, 0, 0, 0);
    cycle("R6 back to back", 0, 0, 1, 16'h8001, 0, 0, 0);
    cycle("R8 idle", 0, 0, 0, 16'hFFFF, 1, 0, 0);
    cycle("R9 match", 0, 0, 0, 0, 0, 1, m_sig);
    check16("R9 match is one", {15'd0, match_o}, 16'd1);
    cycle("R10 hold", 0, 0, 1, 16'h7777, 0, 0, 0);
    cycle("R9 compare with word", 0, 0, 1, 16'h1111, 0, 1, m_sig);
    cycle("R9 mismatch", 0, 0, 0, 0, 0, 1, m_sig ^ 16'h0100);
    cycle("R9 match again", 0, 0, 0, 0, 0, 1, m_sig);
    cycle("R7 R10 start wins", 1, 16'h4000, 1, 16'hBEEF, 0, 1, m_sig);
    for (int i = 0; i < 18; i++) cycle("R11 wrap", 0, 0, 1, 16'(i * 37), 0, 0, 0);
    cycle("R11 start clears", 1, 16'h2000, 0, 0, 0, 0, 0);

    void'($urandom(32'd1357));
    for (int i = 0; i < 3000; i++) begin
      logic st, vld, er, cp;
      logic [15:0] rb;
      st  = ($urandom % 20) == 0;
      vld = ($urandom % 4) != 0;
      er  = ($urandom % 5) == 0;
      cp  = ($urandom % 6) == 0;
      rb  = ($urandom % 2) ? m_sig : 16'($urandom);
      cycle("R3 R4 R5 R9 R11 random", st, 16'($urandom), vld, 16'($urandom), er, cp, rb);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule